// File: doc/BRIEF.md
# SDRAM Command Front-End Decoder

This block is the device-side command interpreter of a four-bank synchronous DRAM model. It samples the control strobes, the address and bank inputs, the clock enable and the data mask on every rising clock edge. It turns them into bank open/close events and into per-beat write and read strobes that an array model can consume. Each write strobe carries the bank, row and column of one burst beat. Each read strobe marks a beat being driven onto the data bus, two cycles after that beat was addressed.

The burst length is fixed at four and the read latency at two cycles. Column addresses advance by wrapping inside an aligned group of four. The block keeps the open row of every bank. It rejects accesses that break the protocol and reports each one with a one-cycle error pulse. It also handles clock suspension and self refresh through the clock enable.

Top module: `sdr_cmd_front`

## Requirements
- R1: An edge with `cs_n` high is a no-operation whatever `ras_n`, `cas_n`, `we_n` carry. It starts no burst, opens or closes no bank, and raises no error.
- R2: The command code on {`ras_n`,`cas_n`,`we_n`} is 011 for activate, 101 for read, 100 for write, 010 for precharge, 001 for refresh and 111 for no-operation. An activate opens bank `ba` with row `addr`. An activate to a bank that is already open raises `cmd_err` for one cycle and is otherwise ignored.
- R3: A read or write to a closed bank is rejected with a one-cycle `cmd_err` and has no other effect. So is a read or write issued while an earlier burst still has beats to issue, which covers the three edges after the command.
- R4: A write accepted at edge n issues beats at edges n to n+3. After each of these edges, `wr_stb` is high for one cycle with `wr_bank`, `wr_row` (the open row of that bank) and `wr_col`. The column keeps its upper bits (above bit 1) and adds the beat index 0..3 modulo 4 to its two low bits.
- R5: When `dqm` is high at an edge where a write beat is issued, that beat's `wr_stb` stays low and the burst continues.
- R6: A read accepted at edge n produces `rd_stb` after edges n+2 to n+5. The bank, row and column follow the same order as R4.
- R7: `dqm` high at edge m suppresses the `rd_stb` produced at edge m+2. It has no effect on write beats that do not fall at edge m.
- R8: A read or write with `addr[10]` high closes its bank at the edge that issues the fourth beat. `bank_open` for that bank is still high after the third beat.
- R9: A precharge with `addr[10]` high closes all four banks. With `addr[10]` low it closes only bank `ba`.
- R10: When `cke` is low at an edge, the following edge is suspended. No command is taken, burst and read pipeline state hold, and `wr_stb`, `rd_stb` and `cmd_err` are low after it.
- R11: A refresh is accepted only with all banks closed and no burst pending; otherwise it raises `cmd_err`. A refresh taken with `cke` low sets `self_ref`. `self_ref` stays high while `cke` is low and clears at the edge that samples `cke` high. Commands are taken again from the edge after that.
- R12: After reset, all banks are closed and every strobe, `self_ref` and `cmd_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low suspends the next edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ROW_W | Row, column and precharge/auto-close option |
| ba | input | BA_W | Bank select |
| dqm | input | 1 | Data mask / read output disable |
| wr_stb | output | 1 | Write beat to be committed |
| wr_bank | output | BA_W | Bank of the write beat |
| wr_row | output | ROW_W | Row of the write beat |
| wr_col | output | COL_W | Column of the write beat |
| rd_stb | output | 1 | Read beat driven on the bus |
| rd_bank | output | BA_W | Bank of the read beat |
| rd_row | output | ROW_W | Row of the read beat |
| rd_col | output | COL_W | Column of the read beat |
| bank_open | output | BANKS | One bit per bank, high while a row is open |
| self_ref | output | 1 | Self refresh in effect |
| cmd_err | output | 1 | One-cycle pulse for a rejected command |

## Verification
The assertions check the properties that hold at every edge. A deselected edge raises no error, and a suspended edge leaves every strobe and the error low. A masked edge commits no write, a precharge-all empties the bank set, and self refresh is never active with a bank open. The bench's scenarios are the only place to see what needs a planned sequence. That covers column wrap order, the two-edge delay of read beats and of the read mask, and the exact edge at which an automatic close lands. It also covers the suspension of a running write burst and the entry to and exit from self refresh.

// File: rtl/sdr_cmd_pkg.sv
package sdr_cmd_pkg;

    localparam int BURST_LEN = 4;
    localparam int CAS_LAT   = 2;

    typedef enum logic [2:0] {
        CMD_OTHER = 3'b000,
        CMD_REF   = 3'b001,
        CMD_PRE   = 3'b010,
        CMD_ACT   = 3'b011,
        CMD_WR    = 3'b100,
        CMD_RD    = 3'b101,
        CMD_NOP   = 3'b111
    } cmd_e;

    function automatic cmd_e decode_cmd(input logic sel_n, input logic [2:0] rcw);
        cmd_e c;
        if (sel_n) begin
            c = CMD_NOP;
        end else begin
            case (rcw)
                3'b001:  c = CMD_REF;
                3'b010:  c = CMD_PRE;
                3'b011:  c = CMD_ACT;
                3'b100:  c = CMD_WR;
                3'b101:  c = CMD_RD;
                3'b111:  c = CMD_NOP;
                default: c = CMD_OTHER;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/sdr_bank_table.sv
module sdr_bank_table #(
    parameter int BANKS = 4,
    parameter int ROW_W = 12,
    localparam int BA_W = $clog2(BANKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_en,
    input  logic [BA_W-1:0]  act_bank,
    input  logic [ROW_W-1:0] act_row,
    input  logic [BANKS-1:0] close_mask,
    output logic [BANKS-1:0] open_o,
    output logic [ROW_W-1:0] row_o [BANKS]
);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
    } bank_t;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        bank_t st_d, st_q;

        always_comb begin
            st_d = st_q;
            if (close_mask[b]) begin
                st_d.open = 1'b0;
            end
            if (act_en && act_bank == BA_W'(b)) begin
                st_d.open = 1'b1;
                st_d.row  = act_row;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign open_o[b] = st_q.open;
        assign row_o[b]  = st_q.row;
    end

endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
    import sdr_cmd_pkg::*;
#(
    parameter int BA_W  = 2,
    parameter int ROW_W = 12,
    parameter int COL_W = 8,
    localparam int BEAT_W = $clog2(BURST_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             start,
    input  logic             start_wr,
    input  logic             start_ap,
    input  logic [BA_W-1:0]  start_bank,
    input  logic [ROW_W-1:0] start_row,
    input  logic [COL_W-1:0] start_col,
    input  logic             dqm,
    output logic             busy,
    output logic             ap_close,
    output logic [BA_W-1:0]  ap_bank,
    output logic             wr_stb,
    output logic [BA_W-1:0]  wr_bank,
    output logic [ROW_W-1:0] wr_row,
    output logic [COL_W-1:0] wr_col,
    output logic             rd_stb,
    output logic [BA_W-1:0]  rd_bank,
    output logic [ROW_W-1:0] rd_row,
    output logic [COL_W-1:0] rd_col
);

    typedef struct packed {
        logic [BA_W-1:0]  bank;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } loc_t;

    typedef struct packed {
        logic [BEAT_W-1:0]        left;
        logic [BEAT_W-1:0]        beat;
        logic                     is_wr;
        logic                     ap;
        loc_t                     loc;
        logic [CAS_LAT-1:0]       rp_v;
        loc_t [CAS_LAT-1:0]       rp_loc;
        logic [CAS_LAT-1:0]       rp_dm;
        logic                     wr_stb;
        loc_t                     wr_loc;
        logic                     rd_stb;
        loc_t                     rd_loc;
    } seq_t;

    seq_t s_d, s_q;
    logic issue, iss_wr, last;
    loc_t iss_loc;

    always_comb begin
        s_d        = s_q;
        s_d.wr_stb = 1'b0;
        s_d.rd_stb = 1'b0;
        issue      = 1'b0;
        iss_wr     = 1'b0;
        iss_loc    = '0;
        last       = 1'b0;
        if (adv) begin
            if (s_q.left != '0) begin
                issue       = 1'b1;
                iss_wr      = s_q.is_wr;
                iss_loc     = s_q.loc;
                iss_loc.col = {s_q.loc.col[COL_W-1:BEAT_W],
                               s_q.loc.col[BEAT_W-1:0] + s_q.beat};
                s_d.left    = s_q.left - BEAT_W'(1);
                s_d.beat    = s_q.beat + BEAT_W'(1);
                last        = (s_q.left == BEAT_W'(1));
            end else if (start) begin
                issue     = 1'b1;
                iss_wr    = start_wr;
                iss_loc   = '{bank: start_bank, row: start_row, col: start_col};
                s_d.left  = BEAT_W'(BURST_LEN - 1);
                s_d.beat  = BEAT_W'(1);
                s_d.is_wr = start_wr;
                s_d.ap    = start_ap;
                s_d.loc   = iss_loc;
            end
            if (issue && iss_wr) begin
                s_d.wr_stb = ~dqm;
                s_d.wr_loc = iss_loc;
            end
            for (int i = CAS_LAT - 1; i > 0; i--) begin
                s_d.rp_v[i]   = s_q.rp_v[i-1];
                s_d.rp_loc[i] = s_q.rp_loc[i-1];
                s_d.rp_dm[i]  = s_q.rp_dm[i-1];
            end
            s_d.rp_v[0]   = issue & ~iss_wr;
            s_d.rp_loc[0] = iss_loc;
            s_d.rp_dm[0]  = dqm;
            s_d.rd_stb    = s_q.rp_v[CAS_LAT-1] & ~s_q.rp_dm[CAS_LAT-1];
            if (s_q.rp_v[CAS_LAT-1]) begin
                s_d.rd_loc = s_q.rp_loc[CAS_LAT-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy     = (s_q.left != '0);
    assign ap_close = last & s_q.ap;
    assign ap_bank  = s_q.loc.bank;
    assign wr_stb   = s_q.wr_stb;
    assign wr_bank  = s_q.wr_loc.bank;
    assign wr_row   = s_q.wr_loc.row;
    assign wr_col   = s_q.wr_loc.col;
    assign rd_stb   = s_q.rd_stb;
    assign rd_bank  = s_q.rd_loc.bank;
    assign rd_row   = s_q.rd_loc.row;
    assign rd_col   = s_q.rd_loc.col;

endmodule

// File: rtl/sdr_cmd_front.sv
module sdr_cmd_front
    import sdr_cmd_pkg::*;
#(
    parameter int BANKS  = 4,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 8,
    parameter int AP_BIT = 10,
    localparam int BA_W  = $clog2(BANKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             cs_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic [ROW_W-1:0] addr,
    input  logic [BA_W-1:0]  ba,
    input  logic             dqm,
    output logic             wr_stb,
    output logic [BA_W-1:0]  wr_bank,
    output logic [ROW_W-1:0] wr_row,
    output logic [COL_W-1:0] wr_col,
    output logic             rd_stb,
    output logic [BA_W-1:0]  rd_bank,
    output logic [ROW_W-1:0] rd_row,
    output logic [COL_W-1:0] rd_col,
    output logic [BANKS-1:0] bank_open,
    output logic             self_ref,
    output logic             cmd_err
);

    typedef struct packed {
        logic cke_prev;
        logic self_ref;
        logic err;
    } ctl_t;

    ctl_t c_d, c_q;
    cmd_e cmd;
    logic live, sel_open, is_rw;
    logic act_go, rw_go, pre_go, ref_go;
    logic busy, ap_close;
    logic [BA_W-1:0]  ap_bank;
    logic [BANKS-1:0] close_mask;
    logic [ROW_W-1:0] rows [BANKS];

    always_comb begin
        c_d      = c_q;
        cmd      = decode_cmd(cs_n, {ras_n, cas_n, we_n});
        live     = c_q.cke_prev & ~c_q.self_ref;
        sel_open = bank_open[ba];
        is_rw    = (cmd == CMD_RD) || (cmd == CMD_WR);
        act_go   = live & (cmd == CMD_ACT) & ~sel_open;
        rw_go    = live & is_rw & sel_open & ~busy;
        pre_go   = live & (cmd == CMD_PRE);
        ref_go   = live & (cmd == CMD_REF) & ~(|bank_open) & ~busy;

        close_mask = '0;
        if (pre_go) begin
            close_mask = addr[AP_BIT] ? {BANKS{1'b1}} : (BANKS'(1) << ba);
        end
        if (ap_close) begin
            close_mask = close_mask | (BANKS'(1) << ap_bank);
        end

        c_d.cke_prev = cke;
        c_d.self_ref = (c_q.self_ref & ~cke) | (ref_go & ~cke);
        c_d.err      = live & (((cmd == CMD_ACT) & sel_open) |
                               (is_rw & ~rw_go) |
                               ((cmd == CMD_REF) & ~ref_go));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{cke_prev: 1'b1, self_ref: 1'b0, err: 1'b0};
        else        c_q <= c_d;
    end

    sdr_bank_table #(.BANKS(BANKS), .ROW_W(ROW_W)) u_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_en     (act_go),
        .act_bank   (ba),
        .act_row    (addr),
        .close_mask (close_mask),
        .open_o     (bank_open),
        .row_o      (rows)
    );

    sdr_burst_seq #(.BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (live),
        .start      (rw_go),
        .start_wr   (cmd == CMD_WR),
        .start_ap   (addr[AP_BIT]),
        .start_bank (ba),
        .start_row  (rows[ba]),
        .start_col  (addr[COL_W-1:0]),
        .dqm        (dqm),
        .busy       (busy),
        .ap_close   (ap_close),
        .ap_bank    (ap_bank),
        .wr_stb     (wr_stb),
        .wr_bank    (wr_bank),
        .wr_row     (wr_row),
        .wr_col     (wr_col),
        .rd_stb     (rd_stb),
        .rd_bank    (rd_bank),
        .rd_row     (rd_row),
        .rd_col     (rd_col)
    );

    assign self_ref = c_q.self_ref;
    assign cmd_err  = c_q.err;

endmodule

// File: rtl/sdr_cmd_front_chk.sv
module sdr_cmd_front_chk #(
    parameter int BANKS = 4,
    parameter int BA_W  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cke,
    input logic             cs_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             ap_bit,
    input logic             dqm,
    input logic [BA_W-1:0]  ba,
    input logic [BANKS-1:0] bank_open,
    input logic             wr_stb,
    input logic             rd_stb,
    input logic             self_ref,
    input logic             cmd_err
);

    logic cke_seen_q;
    logic live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cke_seen_q <= 1'b1;
        else        cke_seen_q <= cke;
    end

    assign live = cke_seen_q & ~self_ref;

    assert_nop_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (live && cs_n) |=> !cmd_err);

    assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !cs_n && {ras_n, cas_n, we_n} == 3'b011 && !bank_open[ba])
        |=> bank_open[$past(ba)]);

    assert_err_on_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(live));

    assert_wmask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (live && dqm) |=> !wr_stb);

    assert_pre_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !cs_n && {ras_n, cas_n, we_n} == 3'b010 && ap_bit)
        |=> (bank_open == '0));

    assert_suspend_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !live |=> (!wr_stb && !rd_stb && !cmd_err));

    assert_sref_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        self_ref |-> (bank_open == '0));

endmodule

bind sdr_cmd_front sdr_cmd_front_chk #(.BANKS(BANKS), .BA_W(BA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ap_bit    (addr[AP_BIT]),
    .dqm       (dqm),
    .ba        (ba),
    .bank_open (bank_open),
    .wr_stb    (wr_stb),
    .rd_stb    (rd_stb),
    .self_ref  (self_ref),
    .cmd_err   (cmd_err)
);

// File: tb/sim_sdr_cmd_front.sv
`timescale 1ns/1ps
module sim_sdr_cmd_front;

    localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                           C_PRE = 3'b010, C_REF = 3'b001, C_NOP = 3'b111;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dqm = 1'b0;
    logic [11:0] addr = '0;
    logic [1:0]  ba = '0;
    logic wr_stb, rd_stb, self_ref, cmd_err;
    logic [1:0] wr_bank, rd_bank;
    logic [11:0] wr_row, rd_row;
    logic [7:0] wr_col, rd_col;
    logic [3:0] bank_open;

    sdr_cmd_front u0 (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba), .dqm(dqm),
        .wr_stb(wr_stb), .wr_bank(wr_bank), .wr_row(wr_row), .wr_col(wr_col),
        .rd_stb(rd_stb), .rd_bank(rd_bank), .rd_row(rd_row), .rd_col(rd_col),
        .bank_open(bank_open), .self_ref(self_ref), .cmd_err(cmd_err)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;
    string cur_req = "R12";

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_cp, m_sr, m_open[4];
    int m_row[4];
    int m_left, m_beat, m_bank, m_brow, m_bcol, k;
    bit m_wr, m_ap;
    bit rdv[int], dmh[int];
    int rdb[int], rdr[int], rdc[int];
    bit e_wr, e_rd, e_err;
    int e_wb, e_wr_row, e_wc, e_rb, e_rr, e_rc;

    function automatic int colf(input int base, input int beat);
        return (base & 'hFC) | ((base + beat) & 3);
    endfunction

    always @(posedge clk) begin
        bit live, busy, issue, iw, any_open, enter;
        bit old_open[4];
        int op, ib, ir, ic;
        if (!rst_n) begin
            m_cp = 1; m_sr = 0; m_left = 0; m_beat = 0; k = 0;
            for (int b = 0; b < 4; b++) begin m_open[b] = 0; m_row[b] = 0; end
            e_wr = 0; e_rd = 0; e_err = 0;
        end else begin
            live = m_cp && !m_sr;
            e_wr = 0; e_rd = 0; e_err = 0; enter = 0;
            if (live) begin
                op = cs_n ? 7 : {ras_n, cas_n, we_n};
                busy = (m_left > 0);
                old_open = m_open;
                any_open = 0;
                for (int b = 0; b < 4; b++) any_open |= old_open[b];
                issue = 0; iw = 0; ib = 0; ir = 0; ic = 0;
                if (busy) begin
                    issue = 1; iw = m_wr; ib = m_bank; ir = m_brow; ic = colf(m_bcol, m_beat);
                    m_left--; m_beat++;
                    if (m_left == 0 && m_ap) m_open[m_bank] = 0;
                end
                case (op)
                    3: if (old_open[ba]) e_err = 1; else begin m_open[ba] = 1; m_row[ba] = addr; end
                    4, 5: if (!old_open[ba] || busy) e_err = 1;
                          else begin
                              issue = 1; iw = (op == 4); ib = ba; ir = m_row[ba]; ic = addr[7:0];
                              m_left = 3; m_beat = 1; m_wr = iw; m_ap = addr[10];
                              m_bank = ba; m_brow = ir; m_bcol = ic;
                          end
                    2: if (addr[10]) begin for (int b = 0; b < 4; b++) m_open[b] = 0; end
                       else m_open[ba] = 0;
                    1: if (any_open || busy) e_err = 1; else if (!cke) enter = 1;
                    default: ;
                endcase
                if (issue && iw) begin e_wr = !dqm; e_wb = ib; e_wr_row = ir; e_wc = ic; end
                if (issue && !iw) begin rdv[k+2] = 1; rdb[k+2] = ib; rdr[k+2] = ir; rdc[k+2] = ic; end
                dmh[k] = dqm;
                if (rdv.exists(k) && !(dmh.exists(k-2) && dmh[k-2])) begin
                    e_rd = 1; e_rb = rdb[k]; e_rr = rdr[k]; e_rc = rdc[k];
                end
                k++;
            end
            if (m_sr && cke) m_sr = 0;
            if (enter) m_sr = 1;
            m_cp = cke;
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, "wr_stb", wr_stb, e_wr);
            if (e_wr && wr_stb) begin
                chk(cur_req, "wr_bank", wr_bank, e_wb);
                chk(cur_req, "wr_row", wr_row, e_wr_row);
                chk(cur_req, "wr_col", wr_col, e_wc);
            end
            chk(cur_req, "rd_stb", rd_stb, e_rd);
            if (e_rd && rd_stb) begin
                chk(cur_req, "rd_bank", rd_bank, e_rb);
                chk(cur_req, "rd_row", rd_row, e_rr);
                chk(cur_req, "rd_col", rd_col, e_rc);
            end
            chk(cur_req, "bank_open", bank_open, {m_open[3], m_open[2], m_open[1], m_open[0]});
            chk(cur_req, "self_ref", self_ref, m_sr);
            chk(cur_req, "cmd_err", cmd_err, e_err);
        end
    end

    task automatic cmd(input logic [2:0] rcw, input logic [1:0] b, input int a,
                       input logic dm = 1'b0, input logic ck = 1'b1, input logic sel_n = 1'b0);
        {ras_n, cas_n, we_n} = rcw;
        ba = b; addr = a[11:0]; dqm = dm; cke = ck; cs_n = sel_n;
        @(negedge clk);
    endtask

    task automatic nop(input logic dm = 1'b0, input logic ck = 1'b1);
        cmd(C_NOP, 2'd0, 0, dm, ck);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R12";
        chk("R12", "bank_open after reset", bank_open, 0);
        chk("R12", "strobes after reset", {wr_stb, rd_stb, self_ref, cmd_err}, 0);

        cur_req = "R2";
        cmd(C_ACT, 0, 'h123);
        chk("R2", "bank0 opened", bank_open[0], 1);
        cmd(C_ACT, 2, 'h456);
        cmd(C_ACT, 0, 'h777);
        chk("R2", "act to open bank err", cmd_err, 1);

        cur_req = "R1";
        cmd(C_WR, 0, 'h00E, 1'b0, 1'b1, 1'b1);
        chk("R1", "deselected write err", cmd_err, 0);
        nop();
        chk("R1", "deselected write strobe", wr_stb, 0);

        cur_req = "R4";
        cmd(C_WR, 0, 'h00E);
        chk("R4", "beat0 col", wr_col, 'h0E);
        chk("R4", "beat0 row", wr_row, 'h123);
        nop(); chk("R4", "beat1 col", wr_col, 'h0F);
        nop(); chk("R4", "beat2 col wraps", wr_col, 'h0C);
        nop(); chk("R4", "beat3 col", wr_col, 'h0D);
        nop(); chk("R4", "burst over", wr_stb, 0);

        cur_req = "R5";
        cmd(C_WR, 2, 'h010);
        chk("R5", "beat0 unmasked", wr_stb, 1);
        nop(1'b1); chk("R5", "beat1 masked", wr_stb, 0);
        nop(); chk("R5", "beat2 col", wr_col, 'h12);
        nop(1'b1); chk("R5", "beat3 masked", wr_stb, 0);
        nop();

        cur_req = "R3";
        cmd(C_RD, 1, 'h000);
        chk("R3", "read closed bank err", cmd_err, 1);
        cmd(C_WR, 0, 'h020);
        nop();
        cmd(C_WR, 0, 'h024);
        chk("R3", "write during burst err", cmd_err, 1);
        chk("R3", "burst continues col", wr_col, 'h22);
        nop(); nop();

        cur_req = "R6";
        cmd(C_RD, 0, 'h005);
        nop(1'b1);
        cur_req = "R7";
        nop(); chk("R6", "read beat0", rd_stb, 1); chk("R6", "read beat0 col", rd_col, 'h05);
        nop(); chk("R7", "read beat1 masked", rd_stb, 0);
        nop(); chk("R6", "read beat2 col", rd_col, 'h07);
        nop(); chk("R6", "read beat3 col", rd_col, 'h04);
        nop(); chk("R6", "read done", rd_stb, 0);

        cur_req = "R8";
        cmd(C_RD, 2, 'h408);
        nop(); nop();
        chk("R8", "bank2 open before last beat", bank_open[2], 1);
        nop();
        chk("R8", "bank2 closed at last beat", bank_open[2], 0);
        nop(); nop();

        cur_req = "R9";
        cmd(C_ACT, 1, 'h0AA);
        cmd(C_PRE, 0, 'h000);
        chk("R9", "single precharge", bank_open, 4'b0010);
        cmd(C_ACT, 3, 'h003);
        cmd(C_PRE, 0, 'h400);
        chk("R9", "precharge all", bank_open, 4'b0000);

        cur_req = "R10";
        cmd(C_ACT, 1, 'h055);
        cmd(C_WR, 1, 'h030, 1'b0, 1'b0);
        chk("R10", "beat0 before suspend", wr_col, 'h30);
        nop();
        chk("R10", "suspended edge", wr_stb, 0);
        nop(); chk("R10", "resumed beat1", wr_col, 'h31);
        nop(); nop();
        nop(1'b0, 1'b0);
        cmd(C_ACT, 3, 'h011);
        chk("R10", "act ignored when suspended", bank_open[3], 0);
        nop();

        cur_req = "R11";
        cmd(C_REF, 0, 0);
        chk("R11", "refresh with open bank err", cmd_err, 1);
        cmd(C_PRE, 0, 'h400);
        cmd(C_REF, 0, 0, 1'b0, 1'b0);
        chk("R11", "self refresh entered", self_ref, 1);
        nop(1'b0, 1'b0); nop(1'b0, 1'b0);
        cmd(C_ACT, 0, 'h009, 1'b0, 1'b0);
        chk("R11", "held in self refresh", self_ref, 1);
        chk("R11", "act ignored in self refresh", bank_open, 0);
        nop();
        chk("R11", "self refresh exit", self_ref, 0);
        cmd(C_ACT, 0, 'h009);
        chk("R11", "act after exit", bank_open[0], 1);
        nop(); nop();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL all watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule